// File: doc/BRIEF.md
# Ring Charge-Sum Centrality Trigger

This block turns the integrated charges and hit flags of one 32-channel detector array into centrality and multiplicity trigger decisions. The array is organised as four rings of eight channels. A bunch-crossing strobe opens a charge-integration gate whose length is programmable in 3 ns units. Each gate cycle is one unit. On the last gate cycle the block samples every channel's digitized charge and hit flag. It then forms one charge sum per ring and a total over the array, and counts the channels that fired.

One clock after the gate closes, the block presents the ring sums, the total and the hit count together with three trigger bits. A central trigger and a semi-central trigger each compare the total charge against a programmable threshold. A multiplicity trigger compares the hit count against a third threshold. The sums and the count stay on the outputs until the next gate produces fresh results. The trigger bits are only high in the single cycle flagged by the valid strobe.

Top module: `ctrig_top`

## Requirements
- R1: After reset, `gate_o`, `trig_valid`, all three trigger bits, every ring sum, the total and the hit count are zero.
- R2: A `bx_strobe` sampled while the gate is closed opens the gate on the next cycle. `gate_o` then stays high for exactly N consecutive cycles, where N = `gate_units` for values 1 to 12, one cycle per 3 ns unit.
- R3: A `gate_units` of 0 gives a one-cycle gate, and values 13 to 15 give a twelve-cycle gate.
- R4: A `bx_strobe` sampled while the gate is open is ignored: it neither lengthens nor restarts the gate.
- R5: Charges and hit flags are sampled on the clock edge that ends the last gate cycle. `trig_valid` pulses high for exactly one cycle, beginning one clock after `gate_o` falls, with the results of that sample.
- R6: Channel i takes charge bits [10i+9:10i] and hit bit i. Ring k sums channels 8k to 8k+7 into field [13k+12:13k] of `ring_sum_o`. `total_o` is the sum of the four rings. With every channel at 1023 the total is 32736 and no field wraps.
- R7: `trig_central` is high when total ≥ `thr_central`, and `trig_semi` is high when total ≥ `thr_semi`. The two tests are independent. Thresholds are sampled on the edge that raises `trig_valid`.
- R8: `hit_cnt_o` is the number of set hit flags (0 to 32). `trig_mult` is high when that count ≥ `thr_mult`.
- R9: Outside the `trig_valid` cycle all trigger bits are low. The ring sums, total and hit count hold their last result until the next one, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one 3 ns gate unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| bx_strobe | input | 1 | Bunch-crossing strobe that opens the gate |
| gate_units | input | 4 | Gate length in 3 ns units |
| charge_in | input | 320 | Packed 10-bit charges, channel i at [10i+9:10i] |
| hit_in | input | 32 | Per-channel hit flags |
| thr_central | input | 15 | Central threshold on the total |
| thr_semi | input | 15 | Semi-central threshold on the total |
| thr_mult | input | 6 | Multiplicity threshold on the hit count |
| gate_o | output | 1 | Integration gate |
| ring_sum_o | output | 52 | Four 13-bit ring sums, ring k at [13k+12:13k] |
| total_o | output | 15 | Total charge over the array |
| hit_cnt_o | output | 6 | Number of hit channels |
| trig_central | output | 1 | Central trigger |
| trig_semi | output | 1 | Semi-central trigger |
| trig_mult | output | 1 | Multiplicity trigger |
| trig_valid | output | 1 | One-cycle result strobe |

## Verification
Some properties are checked on every cycle. The gate never runs past twelve cycles. A falling gate is always followed by a valid strobe, and every valid strobe traces back to a gate. The total always equals the sum of the ring fields, and the trigger bits agree with the thresholds sampled one cycle earlier and are silent outside the valid cycle. Other behaviours show up only in the bench scenarios. These are the exact gate length for each programmed value, including the clamped codes. They also include ignoring a strobe in mid-gate, the correct channel-to-ring mapping of the sums, the full-scale no-wrap case, and threshold ties.

// File: rtl/ctrig_pkg.sv
package ctrig_pkg;

  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_OPEN = 1'b1
  } gate_state_e;

  localparam int unsigned GATE_MAX_UNITS = 12;

endpackage

// File: rtl/ctrig_gate.sv
module ctrig_gate
  import ctrig_pkg::*;
#(
  parameter int unsigned UNIT_W    = 4,
  parameter int unsigned MAX_UNITS = GATE_MAX_UNITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bx_strobe,
  input  logic [UNIT_W-1:0] units,
  output logic              gate_o,
  output logic              last_o
);

  gate_state_e       state_q, state_d;
  logic [UNIT_W-1:0] cnt_q, cnt_d;
  logic [UNIT_W-1:0] units_eff;
  logic              cnt_en;

  // clamp the programmed length into 1..MAX_UNITS
  always_comb begin
    if (units == '0)
      units_eff = UNIT_W'(1);
    else if (units > UNIT_W'(MAX_UNITS))
      units_eff = UNIT_W'(MAX_UNITS);
    else
      units_eff = units;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      GATE_IDLE: begin
        if (bx_strobe) begin
          state_d = GATE_OPEN;
          cnt_d   = units_eff;
          cnt_en  = 1'b1;
        end
      end
      GATE_OPEN: begin
        cnt_en = 1'b1;
        if (cnt_q == UNIT_W'(1)) begin
          state_d = GATE_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - UNIT_W'(1);
        end
      end
      default: begin
        state_d = GATE_IDLE;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_IDLE;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign gate_o = (state_q == GATE_OPEN);
  assign last_o = gate_o && (cnt_q == UNIT_W'(1));

endmodule

// File: rtl/ctrig_adder.sv
module ctrig_adder #(
  parameter int unsigned N_IN  = 8,
  parameter int unsigned IN_W  = 10,
  parameter int unsigned OUT_W = IN_W + $clog2(N_IN)
) (
  input  logic [N_IN*IN_W-1:0] operands,
  output logic [OUT_W-1:0]     sum_o
);

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N_IN; i++) begin
      sum_o = sum_o + OUT_W'(operands[i*IN_W +: IN_W]);
    end
  end

endmodule

// File: rtl/ctrig_popcount.sv
module ctrig_popcount #(
  parameter int unsigned N     = 32,
  parameter int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     bits,
  output logic [CNT_W-1:0] count_o
);

  always_comb begin
    count_o = '0;
    for (int i = 0; i < N; i++) begin
      count_o = count_o + CNT_W'(bits[i]);
    end
  end

endmodule

// File: rtl/ctrig_top.sv
module ctrig_top
  import ctrig_pkg::*;
#(
  parameter int unsigned N_RINGS     = 4,
  parameter int unsigned CH_PER_RING = 8,
  parameter int unsigned CHG_W       = 10,
  parameter int unsigned UNIT_W      = 4,
  localparam int unsigned N_CH       = N_RINGS * CH_PER_RING,
  localparam int unsigned RING_W     = CHG_W + $clog2(CH_PER_RING),
  localparam int unsigned TOT_W      = RING_W + $clog2(N_RINGS),
  localparam int unsigned CNT_W      = $clog2(N_CH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bx_strobe,
  input  logic [UNIT_W-1:0]         gate_units,
  input  logic [N_CH*CHG_W-1:0]     charge_in,
  input  logic [N_CH-1:0]           hit_in,
  input  logic [TOT_W-1:0]          thr_central,
  input  logic [TOT_W-1:0]          thr_semi,
  input  logic [CNT_W-1:0]          thr_mult,
  output logic                      gate_o,
  output logic [N_RINGS*RING_W-1:0] ring_sum_o,
  output logic [TOT_W-1:0]          total_o,
  output logic [CNT_W-1:0]          hit_cnt_o,
  output logic                      trig_central,
  output logic                      trig_semi,
  output logic                      trig_mult,
  output logic                      trig_valid
);

  logic gate_last;

  ctrig_gate #(
    .UNIT_W   (UNIT_W),
    .MAX_UNITS(GATE_MAX_UNITS)
  ) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .bx_strobe(bx_strobe),
    .units    (gate_units),
    .gate_o   (gate_o),
    .last_o   (gate_last)
  );

  // stage 1: sample inputs on the closing edge
  logic [N_CH*CHG_W-1:0] chg_q;
  logic [N_CH-1:0]       hit_q;
  logic                  smp_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= '0;
      hit_q <= '0;
    end else if (gate_last) begin
      chg_q <= charge_in;
      hit_q <= hit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_vld_q <= 1'b0;
    else        smp_vld_q <= gate_last;
  end

  // stage 2: ring sums, total, hit count
  logic [N_RINGS*RING_W-1:0] ring_d;
  logic [TOT_W-1:0]          total_d;
  logic [CNT_W-1:0]          cnt_d;

  for (genvar r = 0; r < N_RINGS; r++) begin : g_ring
    ctrig_adder #(
      .N_IN (CH_PER_RING),
      .IN_W (CHG_W),
      .OUT_W(RING_W)
    ) u_ring_sum (
      .operands(chg_q[r*CH_PER_RING*CHG_W +: CH_PER_RING*CHG_W]),
      .sum_o   (ring_d[r*RING_W +: RING_W])
    );
  end

  ctrig_adder #(
    .N_IN (N_RINGS),
    .IN_W (RING_W),
    .OUT_W(TOT_W)
  ) u_total_sum (
    .operands(ring_d),
    .sum_o   (total_d)
  );

  ctrig_popcount #(
    .N    (N_CH),
    .CNT_W(CNT_W)
  ) u_hits (
    .bits   (hit_q),
    .count_o(cnt_d)
  );

  logic central_d, semi_d, mult_d;

  always_comb begin
    central_d = smp_vld_q && (total_d >= thr_central);
    semi_d    = smp_vld_q && (total_d >= thr_semi);
    mult_d    = smp_vld_q && (cnt_d >= thr_mult);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_sum_o <= '0;
      total_o    <= '0;
      hit_cnt_o  <= '0;
    end else if (smp_vld_q) begin
      ring_sum_o <= ring_d;
      total_o    <= total_d;
      hit_cnt_o  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_central <= 1'b0;
      trig_semi    <= 1'b0;
      trig_mult    <= 1'b0;
      trig_valid   <= 1'b0;
    end else begin
      trig_central <= central_d;
      trig_semi    <= semi_d;
      trig_mult    <= mult_d;
      trig_valid   <= smp_vld_q;
    end
  end

endmodule

// File: rtl/ctrig_checker.sv
module ctrig_checker #(
  parameter int unsigned N_RINGS = 4,
  parameter int unsigned RING_W  = 13,
  parameter int unsigned TOT_W   = 15,
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned MAX_UNITS = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      gate_o,
  input logic [N_RINGS*RING_W-1:0] ring_sum_o,
  input logic [TOT_W-1:0]          total_o,
  input logic [CNT_W-1:0]          hit_cnt_o,
  input logic [TOT_W-1:0]          thr_central,
  input logic [TOT_W-1:0]          thr_semi,
  input logic [CNT_W-1:0]          thr_mult,
  input logic                      trig_central,
  input logic                      trig_semi,
  input logic                      trig_mult,
  input logic                      trig_valid
);

  logic [7:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (gate_o) run_q <= run_q + 8'd1;
    else             run_q <= '0;
  end

  logic [TOT_W+3:0] ring_total;
  always_comb begin
    ring_total = '0;
    for (int k = 0; k < N_RINGS; k++)
      ring_total = ring_total + (TOT_W+4)'(ring_sum_o[k*RING_W +: RING_W]);
  end

  a_r2_gate_max: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> run_q < 8'(MAX_UNITS));

  a_r5_valid_follows_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |=> trig_valid);

  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |=> !trig_valid);

  a_r6_total_matches_rings: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> ring_total == (TOT_W+4)'(total_o));

  a_r7_central_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> trig_central == (total_o >= $past(thr_central)));

  a_r7_semi_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> trig_semi == (total_o >= $past(thr_semi)));

  a_r8_mult_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> trig_mult == (hit_cnt_o >= $past(thr_mult)));

  a_r9_quiet_outside_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_valid |-> !(trig_central || trig_semi || trig_mult));

  a_r9_results_held: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_valid |=> (trig_valid || ($stable(total_o) && $stable(hit_cnt_o))));

endmodule

bind ctrig_top ctrig_checker #(
  .N_RINGS  (N_RINGS),
  .RING_W   (RING_W),
  .TOT_W    (TOT_W),
  .CNT_W    (CNT_W),
  .MAX_UNITS(ctrig_pkg::GATE_MAX_UNITS)
) u_ctrig_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .gate_o      (gate_o),
  .ring_sum_o  (ring_sum_o),
  .total_o     (total_o),
  .hit_cnt_o   (hit_cnt_o),
  .thr_central (thr_central),
  .thr_semi    (thr_semi),
  .thr_mult    (thr_mult),
  .trig_central(trig_central),
  .trig_semi   (trig_semi),
  .trig_mult   (trig_mult),
  .trig_valid  (trig_valid)
);

// File: tb/ctrig_top_bench.sv
module ctrig_top_bench;

  localparam int NR = 4;
  localparam int CPR = 8;
  localparam int NCH = 32;
  localparam int CW = 10;
  localparam int RW = 13;
  localparam int TW = 15;
  localparam int KW = 6;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               bx_strobe;
  logic [3:0]         gate_units;
  logic [NCH*CW-1:0]  charge_in;
  logic [NCH-1:0]     hit_in;
  logic [TW-1:0]      thr_central, thr_semi;
  logic [KW-1:0]      thr_mult;
  logic               gate_o;
  logic [NR*RW-1:0]   ring_sum_o;
  logic [TW-1:0]      total_o;
  logic [KW-1:0]      hit_cnt_o;
  logic               trig_central, trig_semi, trig_mult, trig_valid;

  always #2 clk = ~clk;

  ctrig_top u_ctrig_top (
    .clk(clk), .rst_n(rst_n), .bx_strobe(bx_strobe), .gate_units(gate_units),
    .charge_in(charge_in), .hit_in(hit_in), .thr_central(thr_central),
    .thr_semi(thr_semi), .thr_mult(thr_mult), .gate_o(gate_o),
    .ring_sum_o(ring_sum_o), .total_o(total_o), .hit_cnt_o(hit_cnt_o),
    .trig_central(trig_central), .trig_semi(trig_semi), .trig_mult(trig_mult),
    .trig_valid(trig_valid)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  int chg[NCH];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int u);
    if (u == 0) return 1;
    if (u > 12) return 12;
    return u;
  endfunction

  function automatic int exp_ring(input int k);
    int s = 0;
    for (int i = 0; i < CPR; i++) s += chg[k*CPR + i];
    return s;
  endfunction

  function automatic int exp_hits(input logic [NCH-1:0] h);
    int c = 0;
    for (int i = 0; i < NCH; i++) c += int'(h[i]);
    return c;
  endfunction

  task automatic load_charges();
    for (int i = 0; i < NCH; i++) charge_in[i*CW +: CW] = chg[i][CW-1:0];
  endtask

  task automatic run_event(input int units, input bit retrig);
    int len, tot, hits;
    int held_tot;
    gate_units = units[3:0];
    load_charges();
    tot = 0;
    for (int k = 0; k < NR; k++) tot += exp_ring(k);
    hits = exp_hits(hit_in);
    bx_strobe = 1'b1;
    @(negedge clk);
    bx_strobe = 1'b0;
    len = 0;
    while (gate_o && len < 40) begin
      len++;
      bx_strobe = (retrig && len == 1);
      @(negedge clk);
    end
    bx_strobe = 1'b0;
    // R2 R3 R4 gate length
    check(len == exp_len(units), retrig ? "R4 gate length after mid-gate strobe" : "R2/R3 gate length", len, exp_len(units));
    check(trig_valid == 1'b0, "R5 no result while gate falls", int'(trig_valid), 0);
    @(negedge clk);
    check(trig_valid == 1'b1, "R5 valid one clock after gate", int'(trig_valid), 1);
    for (int k = 0; k < NR; k++)
      check(int'(ring_sum_o[k*RW +: RW]) == exp_ring(k), "R6 ring sum", int'(ring_sum_o[k*RW +: RW]), exp_ring(k));
    check(int'(total_o) == tot, "R6 total", int'(total_o), tot);
    check(int'(hit_cnt_o) == hits, "R8 hit count", int'(hit_cnt_o), hits);
    check(trig_central == (tot >= int'(thr_central)), "R7 central", int'(trig_central), int'(tot >= int'(thr_central)));
    check(trig_semi == (tot >= int'(thr_semi)), "R7 semi", int'(trig_semi), int'(tot >= int'(thr_semi)));
    check(trig_mult == (hits >= int'(thr_mult)), "R8 multiplicity", int'(trig_mult), int'(hits >= int'(thr_mult)));
    held_tot = int'(total_o);
    // scramble inputs; results must hold
    for (int i = 0; i < NCH; i++) charge_in[i*CW +: CW] = CW'($urandom);
    hit_in = $urandom;
    @(negedge clk);
    check(!trig_valid && !trig_central && !trig_semi && !trig_mult, "R9 triggers quiet",
          int'({trig_valid, trig_central, trig_semi, trig_mult}), 0);
    check(int'(total_o) == held_tot, "R9 total held", int'(total_o), held_tot);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int tot;
    void'($urandom(32'd20041));
    rst_n = 1'b0; bx_strobe = 1'b0; gate_units = 4'd3; charge_in = '0; hit_in = '0;
    thr_central = '0; thr_semi = '0; thr_mult = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!gate_o && !trig_valid && !trig_central && !trig_semi && !trig_mult, "R1 reset flags",
          int'({gate_o, trig_valid, trig_central, trig_semi, trig_mult}), 0);
    check(ring_sum_o == '0 && total_o == '0 && hit_cnt_o == '0, "R1 reset data", int'(total_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // full scale, ties on thresholds (R6, R7, R8)
    for (int i = 0; i < NCH; i++) chg[i] = 1023;
    hit_in = '1; thr_central = 15'd32736; thr_semi = 15'd32737; thr_mult = 6'd32;
    run_event(12, 1'b0);
    // empty event, zero thresholds; gate code 0 (R3)
    for (int i = 0; i < NCH; i++) chg[i] = 0;
    hit_in = '0; thr_central = '0; thr_semi = 15'd1; thr_mult = 6'd0;
    run_event(0, 1'b0);
    // single channel per ring mapping check (R6)
    for (int i = 0; i < NCH; i++) chg[i] = (i % CPR == 7) ? (i + 1) * 10 : 0;
    hit_in = 32'h8000_0001; thr_central = 15'd500; thr_semi = 15'd99; thr_mult = 6'd3;
    run_event(15, 1'b0);
    run_event(13, 1'b1);
    run_event(1, 1'b1);
    run_event(5, 1'b1);

    // random events
    for (int e = 0; e < 40; e++) begin
      for (int i = 0; i < NCH; i++) chg[i] = int'($urandom_range(0, 1023));
      hit_in = $urandom;
      tot = 0;
      for (int k = 0; k < NR; k++) tot += exp_ring(k);
      thr_central = TW'(tot + int'($urandom_range(0, 40)) - 20);
      thr_semi    = TW'($urandom_range(0, 32767));
      thr_mult    = KW'($urandom_range(0, 33));
      run_event(int'($urandom_range(0, 15)), bit'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule